// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous request port and an asynchronous 16M x 4-bit DRAM. A request carries a 24-bit word address, a direction bit and a 4-bit write word. The controller splits the address into a row part and a column part and sends both over one multiplexed address bus. It produces the row strobe, column strobe, write enable and output enable for the memory. Every timing figure is a parameter counted in clock cycles, worked out from the memory's nanosecond limits at the clock period in use.

After an access the row stays open. Further requests to the same row are served as page cycles: the column strobe toggles while the row strobe stays low. The row is closed in three cases: a request names another row, a refresh falls due, or a counter of row-strobe-low cycles reaches its guard limit. An interval timer raises a refresh demand. The refresh is done with the column strobe lowered before the row strobe, so the memory's internal counter supplies the row. A pending refresh wins over any new request.

Writes are early writes. Write enable and the write data are set up before the column strobe falls, and output enable stays high. Read data is taken at the end of the column-strobe-low window and returned with a one-cycle valid strobe.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is applied, and after it, until a request or refresh starts, the row strobe, column strobe, write enable and output enable are all high, the data drive enable is low and the read valid strobe is low.
- R2: The row address is request address bits [23:11] and is on the address bus when the row strobe falls. The column address is request address bits [10:0] and is on address bus bits [10:0] when the column strobe falls.
- R3: Each accepted read produces exactly one read valid pulse. Pulses come in request order. Each carries the word most recently written to that address, in whatever order requests to different rows were served.
- R4: On a write, write enable is low and the data drive enable is high when the column strobe falls. Write enable stays low while the column strobe is low, and output enable stays high throughout.
- R5: A request to the row that is already open is served without raising the row strobe. Two column strobe falls within one open row are at least T_PC (8) cycles apart.
- R6: A request to a row other than the open one closes it. The row strobe is then high for at least the precharge time (8 cycles) before it falls again.
- R7: A refresh lowers the column strobe before the row strobe, with write enable high. Refresh is served before any new request. Two refreshes are never further apart than the refresh interval plus 40 cycles, even under continuous page-hit traffic.
- R8: The row strobe is never low for more than T_RAS_MAX cycles. A long run of page hits is broken up by row closures.
- R9: The column strobe stays low for at least 3 cycles. A read's column strobe rises no earlier than 12 cycles after the row strobe fell. Row strobe falls are at least 20 cycles apart.
- R10: A request is taken only in a cycle where req_ready is high. req_ready is never high while the column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address: row in [23:11], column in [10:0] |
| req_wdata | input | 4 | Write word |
| rd_valid | output | 1 | Read word valid for one cycle |
| rd_data | output | 4 | Read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
Some properties are checked on every cycle. Write enable stays high at a refresh row-strobe fall. Write enable low implies output enable high and data driven. A read valid pulse follows a cycle with the column strobe low. The refresh acknowledge only answers a pending demand, and a new demand never lands on one that has not been served. The row-strobe-low count stays under its maximum. req_ready is never high while the column strobe is low.

Other behaviours show only in the bench's scenarios, where a behavioural memory model checks them: that data written comes back correctly, that a run of same-row requests opens the row only once, and that alternating rows reopens every time. The same goes for the address split at the extreme addresses, the nanosecond-derived minimum widths, and the refresh count over a long idle stretch.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RADR, S_RCD, S_CADR, S_CAS, S_CP, S_OPEN, S_PRE, S_CBR_C, S_CBR_R
  } fpm_state_t;
endpackage

// File: rtl/fpm_ref_timer.sv
`timescale 1ns/1ps
module fpm_ref_timer #(
  parameter int INTERVAL = 3900,
  localparam int CW = $clog2(INTERVAL)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  logic [CW-1:0] cnt, cnt_nx;
  logic          tick, pend_nx;

  always_comb begin
    tick    = (cnt == '0);
    cnt_nx  = tick ? CW'(INTERVAL - 1) : cnt - 1'b1;
    pend_nx = tick | (pend & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CW'(INTERVAL - 1);
      pend <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      pend <= pend_nx;
    end
  end

  // R7: the sequencer acknowledges only a demand that exists
  a_r7_ack_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);
  // R7: a demand is always served before the next one falls due
  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !pend);
endmodule

// File: rtl/fpm_ras_limit.sv
`timescale 1ns/1ps
module fpm_ras_limit #(
  parameter int T_RAS_MAX = 2500,
  parameter int GUARD     = 8,
  localparam int LIMIT = T_RAS_MAX - GUARD - 1,
  localparam int CW    = $clog2(T_RAS_MAX + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic expire
);
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx = ras_low ? cnt + 1'b1 : '0;
    expire = (cnt >= CW'(LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  // R8: the sequencer closes the row before the maximum low time
  a_r8_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (cnt < CW'(T_RAS_MAX)));
endmodule

// File: rtl/fpm_seq.sv
`timescale 1ns/1ps
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int MA_W   = 13,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 8,
  parameter int T_CAS  = 3,
  parameter int T_CP   = 3,
  parameter int T_RP   = 8,
  parameter int T_CBR  = 12,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ref_pend,
  output logic              ref_ack,
  input  logic              ras_expire,
  output logic              ras_low,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [MA_W-1:0]   ma,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  fpm_state_t        state, state_nx;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_q;
  logic              hit, accept, ld_row, ld_col, cap;
  logic [MA_W-1:0]   row_ext, col_ext;

  always_comb begin
    hit       = (req_row == row_q);
    req_ready = !ref_pend &&
                ((state == S_IDLE) || (state == S_OPEN && hit && !ras_expire));
    accept    = req_valid && req_ready;
    state_nx  = state;
    cnt_nx    = cnt;
    ld_row    = 1'b0;
    ld_col    = 1'b0;
    ref_ack   = 1'b0;
    cap       = 1'b0;
    case (state)
      S_IDLE: begin
        if (ref_pend) begin
          state_nx = S_CBR_C;
          ref_ack  = 1'b1;
        end else if (accept) begin
          state_nx = S_RADR;
          ld_row   = 1'b1;
          ld_col   = 1'b1;
        end
      end
      S_RADR: begin
        state_nx = S_RCD;
        cnt_nx   = CNT_W'(T_RCD - 1);
      end
      S_RCD:  if (cnt == '0) state_nx = S_CADR; else cnt_nx = cnt - 1'b1;
      S_CADR: begin
        state_nx = S_CAS;
        cnt_nx   = CNT_W'(T_CAS - 1);
      end
      S_CAS: begin
        if (cnt == '0) begin
          state_nx = S_CP;
          cnt_nx   = CNT_W'(T_CP - 1);
          cap      = !wr_q;
        end else cnt_nx = cnt - 1'b1;
      end
      S_CP:   if (cnt == '0) state_nx = S_OPEN; else cnt_nx = cnt - 1'b1;
      S_OPEN: begin
        if (accept) begin
          state_nx = S_CADR;
          ld_col   = 1'b1;
        end else if (ref_pend || ras_expire || req_valid) begin
          state_nx = S_PRE;
          cnt_nx   = CNT_W'(T_RP - 1);
        end
      end
      S_PRE:  if (cnt == '0) state_nx = S_IDLE; else cnt_nx = cnt - 1'b1;
      S_CBR_C: begin
        state_nx = S_CBR_R;
        cnt_nx   = CNT_W'(T_CBR - 1);
      end
      S_CBR_R: begin
        if (cnt == '0) begin
          state_nx = S_PRE;
          cnt_nx   = CNT_W'(T_RP - 1);
        end else cnt_nx = cnt - 1'b1;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      state    <= state_nx;
      cnt      <= cnt_nx;
      rd_valid <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (ld_row) row_q <= req_row;
      if (ld_col) begin
        col_q <= req_col;
        wd_q  <= req_wdata;
        wr_q  <= req_write;
      end
      if (cap) rd_data <= dq_in;
    end
  end

  always_comb begin
    row_ext = '0;
    row_ext[ROW_W-1:0] = row_q;
    col_ext = '0;
    col_ext[COL_W-1:0] = col_q;
    ras_low = (state inside {S_RCD, S_CADR, S_CAS, S_CP, S_OPEN});
    ras_n   = !(ras_low || state == S_CBR_R);
    cas_n   = !(state inside {S_CAS, S_CBR_C, S_CBR_R});
    we_n    = !(wr_q && (state inside {S_CADR, S_CAS}));
    dq_oe   = wr_q && (state inside {S_CADR, S_CAS});
    oe_n    = !(!wr_q && state == S_CAS);
    dq_out  = wd_q;
    if (state inside {S_RADR, S_RCD})      ma = row_ext;
    else if (state inside {S_CADR, S_CAS}) ma = col_ext;
    else                                   ma = '0;
  end

  // R3: read data is returned right after an output-enabled column cycle
  a_r3_valid_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!cas_n && !oe_n));
  // R6: once the row strobe rises it stays high for more than one cycle
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int T_RCD        = 8,
  parameter int T_CAS        = 3,
  parameter int T_CP         = 3,
  parameter int T_RP         = 8,
  parameter int T_CBR        = 12,
  parameter int T_RAS_MAX    = 2500,
  parameter int REF_INTERVAL = 3900,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int T_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_B   = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int T_C   = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX = (T_C > T_CBR) ? T_C : T_CBR;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int GUARD = T_CAS + T_CP + 2;

  logic rst_m, rst_s;
  logic ref_pend, ref_ack, ras_low, ras_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  fpm_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_s), .ack(ref_ack), .pend(ref_pend));

  fpm_ras_limit #(.T_RAS_MAX(T_RAS_MAX), .GUARD(GUARD)) u_limit (
    .clk(clk), .rst_n(rst_s), .ras_low(ras_low), .expire(ras_expire));

  fpm_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_CBR(T_CBR), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_s),
    .req_valid(req_valid), .req_write(req_write),
    .req_row(req_addr[ADDR_W-1:COL_W]), .req_col(req_addr[COL_W-1:0]),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .ref_pend(ref_pend), .ref_ack(ref_ack),
    .ras_expire(ras_expire), .ras_low(ras_low),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .ma(dram_addr), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe), .dq_in(dram_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // R7: a refresh row-strobe fall with the column strobe low keeps write enable high
  a_r7_cbr_we_high: assert property (@(posedge clk) disable iff (!rst_s)
    ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);
  // R4: during a write the output enable is off and data is driven
  a_r4_write_oe_off: assert property (@(posedge clk) disable iff (!rst_s)
    !dram_we_n |-> (dram_oe_n && dram_dq_oe));
  // R10: no request is taken while a column cycle is running
  a_r10_ready_idle_cas: assert property (@(posedge clk) disable iff (!rst_s)
    req_ready |-> dram_cas_n);
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;
  localparam int CLK_NS   = 4;
  localparam int RAS_MAX  = 80;
  localparam int REF_IV   = 300;
  localparam int REF_BND  = REF_IV + 40;
  localparam int CAS_MIN  = (12 + CLK_NS - 1) / CLK_NS;
  localparam int RAC_MIN  = (45 + CLK_NS - 1) / CLK_NS;
  localparam int PC_MIN   = (31 + CLK_NS - 1) / CLK_NS;
  localparam int RC_MIN   = (80 + CLK_NS - 1) / CLK_NS;
  localparam int RP_MIN   = (30 + CLK_NS - 1) / CLK_NS;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [23:0] req_addr;
  logic [3:0]  req_wdata, rd_data, dq_out, dq_in, rd_word;
  logic rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [12:0] ma;

  fpm_dram_ctrl #(.T_RAS_MAX(RAS_MAX), .REF_INTERVAL(REF_IV)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(ma), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int total = 0, bad = 0;
  bit done = 0, started = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] dflt(int a);
    return 4'(a) ^ 4'(a >> 11);
  endfunction

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  // Behavioural memory with timing monitors
  logic [3:0] mem [int];
  logic [12:0] cur_row, last_row;
  logic [10:0] last_col;
  bit prev_ras, prev_cas, is_rd, cas_wr, ref_late;
  int low_cnt, high_cnt, rc_cnt, pc_cnt, cas_cnt, since_ras, since_ref;
  int acc_falls, cbr_count, model_writes;

  assign dq_in = (!oe_n && !cas_n) ? rd_word : 4'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1; low_cnt = 0; high_cnt = 100; rc_cnt = 100;
      pc_cnt = 100; cas_cnt = 0; since_ras = 0; since_ref = 0; ref_late = 0;
      is_rd = 0; cas_wr = 0;
    end else begin
      since_ref++;
      if (since_ref > REF_BND && !ref_late) begin
        ref_late = 1;
        chk(0, "R7 refresh interval", since_ref, REF_BND);
      end
      if (prev_ras && !ras_n) begin
        if (!cas_n) begin
          cbr_count++; since_ref = 0; ref_late = 0;
          if (!we_n) chk(0, "R7 cbr write enable", 0, 1);
        end else begin
          acc_falls++; cur_row = ma; last_row = ma;
        end
        if (high_cnt < RP_MIN) chk(0, "R6 precharge", high_cnt, RP_MIN);
        if (rc_cnt < RC_MIN) chk(0, "R9 cycle time", rc_cnt, RC_MIN);
        rc_cnt = 0; low_cnt = 0; since_ras = 0; pc_cnt = 100;
      end
      if (!prev_ras && ras_n) begin
        if (low_cnt > RAS_MAX) chk(0, "R8 ras low time", low_cnt, RAS_MAX);
        high_cnt = 0;
      end
      if (prev_cas && !cas_n && !ras_n && !prev_ras) begin
        if (pc_cnt < PC_MIN) chk(0, "R5 page cycle", pc_cnt, PC_MIN);
        last_col = ma[10:0];
        if (!we_n) begin
          if (!oe_n || !dq_oe) chk(0, "R4 write setup", {oe_n, dq_oe}, 3);
          mem[int'({cur_row, ma[10:0]})] = dq_out;
          model_writes++;
          is_rd = 0; cas_wr = 1;
        end else begin
          rd_word <= mem.exists(int'({cur_row, ma[10:0]})) ?
                     mem[int'({cur_row, ma[10:0]})] : dflt(int'({cur_row, ma[10:0]}));
          is_rd = 1; cas_wr = 0;
        end
        pc_cnt = 0; cas_cnt = 0;
      end
      if (!cas_n && !prev_cas && cas_wr && we_n)
        chk(0, "R4 we held", 1, 0);
      if (!prev_cas && cas_n && !ras_n) begin
        if (cas_cnt < CAS_MIN) chk(0, "R9 cas width", cas_cnt, CAS_MIN);
        if (is_rd && since_ras < RAC_MIN) chk(0, "R9 row access", since_ras, RAC_MIN);
        cas_wr = 0;
      end
      if (!ras_n) begin low_cnt++; since_ras++; end else high_cnt++;
      if (!cas_n) cas_cnt++;
      rc_cnt++; pc_cnt++;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  // Reference: shadow memory and queue of expected read words
  logic [3:0] shadow [int];
  logic [3:0] exp_q [$];
  int reads_out = 0;

  always @(negedge clk) begin
    if (rst_n && started) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected read valid", 1, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          reads_out++;
          chk(rd_data == e, "R3 read data", rd_data, e);
        end
      end
      if (!cas_n && req_ready) chk(0, "R10 ready during cas", 1, 0);
    end
  end

  task automatic issue(bit wr, logic [23:0] a, logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(int'(a)));
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ref();
    int c;
    idle(1);
    c = cbr_count;
    while (cbr_count == c) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a0, c0, w0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    acc_falls = 0; cbr_count = 0; model_writes = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid, "R1 drive and valid in reset", {dq_oe, rd_valid}, 0);
    rst_n = 1;
    started = 1;
    repeat (4) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 idle after reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(req_ready == 1, "R10 ready when idle", req_ready, 1);

    // R5: page hits within one row open it once
    wait_ref();
    a0 = acc_falls;
    for (int i = 0; i < 4; i++) issue(1, {13'h0123, 11'(i * 5)}, 4'(i + 9));
    for (int i = 0; i < 4; i++) issue(0, {13'h0123, 11'(i * 5)}, 4'h0);
    idle(20);
    chk(acc_falls - a0 == 1, "R5 single row open for hits", acc_falls - a0, 1);

    // R6: alternating rows reopen every time
    wait_ref();
    a0 = acc_falls;
    issue(1, {13'h0AAA, 11'h010}, 4'h3);
    issue(1, {13'h1555, 11'h010}, 4'hC);
    issue(0, {13'h0AAA, 11'h010}, 4'h0);
    issue(0, {13'h1555, 11'h010}, 4'h0);
    idle(30);
    chk(acc_falls - a0 == 4, "R6 row miss reopens", acc_falls - a0, 4);

    // R2: address split at the extremes
    w0 = model_writes;
    issue(1, 24'hFFFFFF, 4'h5);
    idle(30);
    chk(model_writes == w0 + 1, "R4 write reached memory", model_writes - w0, 1);
    chk(last_row == 13'h1FFF, "R2 row bits high", last_row, 13'h1FFF);
    chk(last_col == 11'h7FF, "R2 column bits high", last_col, 11'h7FF);
    issue(1, 24'h800400, 4'hA);
    idle(30);
    chk(last_row == 13'h1000, "R2 row msb", last_row, 13'h1000);
    chk(last_col == 11'h400, "R2 column msb", last_col, 11'h400);
    issue(0, 24'hFFFFFF, 4'h0);
    issue(0, 24'h800400, 4'h0);
    idle(30);

    // R8 and R7: a long stream of hits is broken up and refresh still runs
    a0 = acc_falls; c0 = cbr_count;
    for (int i = 0; i < 40; i++) issue(0, {13'h0042, 11'(i)}, 4'h0);
    idle(30);
    chk(acc_falls - a0 >= 4, "R8 long hit run closes row", acc_falls - a0, 4);
    chk(cbr_count - c0 >= 1, "R7 refresh under traffic", cbr_count - c0, 1);

    // R7: refresh rate while idle
    c0 = cbr_count;
    idle(1500);
    chk(cbr_count - c0 >= 4, "R7 refresh count idle", cbr_count - c0, 4);

    // R3: mixed traffic over two rows
    for (int i = 0; i < 60; i++) begin
      logic [23:0] a;
      a = {13'(5 + ($urandom % 2)), 11'($urandom % 8)};
      issue(1'($urandom % 2), a, 4'($urandom));
    end
    idle(60);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    chk(reads_out > 20, "R3 read count", reads_out, 21);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule